// File: doc/BRIEF.md
# Ping-pong receive frame buffer

This block sits behind the receive side of a small Ethernet MAC. Frame bytes arrive on a byte-wide stream that has a valid strobe and a marker on the final byte. The block packs the bytes into 32-bit words and stores each frame in one of two equal receive areas. After reset the first area is used, and the areas then alternate. When a frame ends, the area that received it is marked complete with a done flag. Software finds the flag by polling or through a one-cycle interrupt, reads the frame over a word-addressed 32-bit register bus, and then clears the flag so the area can be used again.

A frame may begin while the area next in line still holds unread data. In that case the whole frame is discarded and a drop counter advances. The alternation does not move on, so the next frame that arrives after software frees that area lands there. Software therefore checks the area it expects next and then the other one.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After reset both done flags, both interrupt enables, the drop counter and the interrupt output are zero, and both status words read as zero.
- R2: The first frame accepted after reset goes to area 0 (data at word address 0x400). Each accepted frame switches the target area, and a discarded frame leaves the target unchanged. Area 1 data starts at word address 0x600.
- R3: Byte k of a stored frame sits in data word k/4 of its area, at bits [31-8*(k%4) -: 8]. The first byte is the most significant. The unused low bytes of a partial last word read as zero.
- R4: The status word of area 0 is at word address 0x5FF and that of area 1 is at 0x7FF. Bit 0 is the done flag and bit 3 is the interrupt enable. All other bits read zero. The done flag of the receiving area becomes set at the end of each accepted frame. Read data appears on bus_rdata in the cycle after bus_rd.
- R5: A bus write to a status word loads the interrupt enable from write data bit 3. It clears the done flag when write data bit 0 is 0, and it leaves the done flag unchanged when bit 0 is 1.
- R6: A frame whose first byte arrives while the target area's done flag is set is discarded in full. That area's data and status stay unchanged, and drop_count increases by exactly one.
- R7: rx_irq is high for exactly one cycle, the cycle after the final byte of an accepted frame is taken, and only if the receiving area's interrupt enable is set.
- R8: Each area stores at most 511 words (2044 bytes). Later bytes of a longer frame are ignored, the status word is not overwritten, and the frame still completes normally at its final byte.
- R9: Bus writes to data words have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | rx_data carries a byte this cycle |
| rx_last | input | 1 | This byte is the final byte of the frame |
| bus_addr | input | 11 | Word address on the register bus |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| drop_count | output | 16 | Count of discarded frames, wraps |

## Verification
The hardest case to reach is a discard. It needs both areas unread at the moment a new frame begins, and it must then be shown that the discard left the target area unchanged. The stimulus fills area 0 and then area 1 with software not clearing either flag, sends a third frame, and reads back the old contents of area 0. Software then frees only area 0, and the next frame must land there. That confirms the alternation did not advance on the discard. A frame of 2050 bytes then fills area 1 past its capacity, to check that storage stops at the last data word and that the status word survives.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_IE_BIT   = 3;
  localparam int WORD_W        = 32;

  function automatic logic [WORD_W-1:0] make_status(input logic done, input logic ie);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_DONE_BIT] = done;
    w[STAT_IE_BIT]   = ie;
    return w;
  endfunction
endpackage

// File: rtl/rxpp_ram.sv
module rxpp_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxpp_packer.sv
module rxpp_packer #(
  parameter int BUF_AW = 9,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [1:0]        done_bits,
  input  logic [1:0]        ie_bits,
  output logic              ram_we,
  output logic [BUF_AW:0]   ram_waddr,
  output logic [31:0]       ram_wdata,
  output logic              frame_fin,
  output logic              fin_sel,
  output logic              wr_sel,
  output logic              frm_busy,
  output logic              rx_irq,
  output logic [CNT_W-1:0]  drop_count
);
  localparam logic [BUF_AW-1:0] CAP = {BUF_AW{1'b1}};

  logic              dropping;
  logic [BUF_AW-1:0] widx;
  logic [1:0]        bpos;
  logic [31:0]       acc;
  logic [31:0]       acc_nx;
  logic              discard;
  logic              room;

  always_comb begin
    discard   = frm_busy ? dropping : done_bits[wr_sel];
    room      = (widx != CAP);
    acc_nx    = ((bpos == 2'd0) ? 32'h0 : acc) | ({rx_data, 24'h0} >> {bpos, 3'b000});
    ram_we    = rx_valid && !discard && room && ((bpos == 2'd3) || rx_last);
    ram_waddr = {wr_sel, widx};
    ram_wdata = acc_nx;
    frame_fin = rx_valid && rx_last && !discard;
    fin_sel   = wr_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sel     <= 1'b0;
      frm_busy   <= 1'b0;
      dropping   <= 1'b0;
      widx       <= '0;
      bpos       <= 2'd0;
      acc        <= '0;
      rx_irq     <= 1'b0;
      drop_count <= '0;
    end else begin
      rx_irq <= 1'b0;
      if (rx_valid && !frm_busy && done_bits[wr_sel])
        drop_count <= drop_count + 1'b1;
      if (rx_valid) begin
        if (rx_last) begin
          frm_busy <= 1'b0;
          dropping <= 1'b0;
          widx     <= '0;
          bpos     <= 2'd0;
          if (!discard) begin
            wr_sel <= ~wr_sel;
            rx_irq <= ie_bits[wr_sel];
          end
        end else begin
          frm_busy <= 1'b1;
          dropping <= discard;
          bpos     <= bpos + 2'd1;
          acc      <= acc_nx;
          if ((bpos == 2'd3) && room && !discard) widx <= widx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxpp_status.sv
module rxpp_status
  import rxpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stat,
  input  logic        rd_stat,
  input  logic        rd_ram,
  input  logic        bsel,
  input  logic        wd_done,
  input  logic        wd_ie,
  input  logic        frame_fin,
  input  logic        fin_sel,
  input  logic [31:0] ram_q,
  output logic [1:0]  done_bits,
  output logic [1:0]  ie_bits,
  output logic [31:0] rdata
);
  logic        rd_stat_q;
  logic        rd_ram_q;
  logic [31:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_bits <= 2'b00;
      ie_bits   <= 2'b00;
      rd_stat_q <= 1'b0;
      rd_ram_q  <= 1'b0;
      stat_q    <= '0;
    end else begin
      if (wr_stat) begin
        ie_bits[bsel] <= wd_ie;
        if (!wd_done) done_bits[bsel] <= 1'b0;
      end
      if (frame_fin) done_bits[fin_sel] <= 1'b1;
      rd_stat_q <= rd_stat;
      rd_ram_q  <= rd_ram;
      stat_q    <= make_status(done_bits[bsel], ie_bits[bsel]);
    end
  end

  assign rdata = rd_stat_q ? stat_q : (rd_ram_q ? ram_q : 32'h0);
endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong #(
  parameter int BUF_AW      = 9,
  parameter int BUS_AW      = 11,
  parameter int REGION_BASE = 'h400,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_last,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rx_irq,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int TAG_W = BUS_AW - BUF_AW - 1;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(REGION_BASE >> (BUF_AW + 1));

  logic              hit, is_stat, bsel;
  logic [BUF_AW-1:0] idx;
  logic              ram_we;
  logic [BUF_AW:0]   ram_waddr;
  logic [31:0]       ram_wdata, ram_q;
  logic              frame_fin, fin_sel, wr_sel, frm_busy;
  logic [1:0]        done_bits, ie_bits;
  logic              wdata_unused;

  assign hit     = (bus_addr[BUS_AW-1:BUF_AW+1] == TAG);
  assign bsel    = bus_addr[BUF_AW];
  assign idx     = bus_addr[BUF_AW-1:0];
  assign is_stat = hit && (&idx);
  assign wdata_unused = ^{bus_wdata[31:4], bus_wdata[2:1]};

  rxpp_packer #(.BUF_AW(BUF_AW), .CNT_W(CNT_W)) u_packer (
    .clk(clk), .rst(rst),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .done_bits(done_bits), .ie_bits(ie_bits),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .frame_fin(frame_fin), .fin_sel(fin_sel), .wr_sel(wr_sel),
    .frm_busy(frm_busy), .rx_irq(rx_irq), .drop_count(drop_count)
  );

  rxpp_ram #(.AW(BUF_AW + 1), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(bus_rd), .raddr({bsel, idx}), .rdata(ram_q)
  );

  rxpp_status u_status (
    .clk(clk), .rst(rst),
    .wr_stat(bus_wr && is_stat),
    .rd_stat(bus_rd && is_stat),
    .rd_ram(bus_rd && hit && !is_stat),
    .bsel(bsel), .wd_done(bus_wdata[0]), .wd_ie(bus_wdata[3]),
    .frame_fin(frame_fin), .fin_sel(fin_sel), .ram_q(ram_q),
    .done_bits(done_bits), .ie_bits(ie_bits), .rdata(bus_rdata)
  );
endmodule

// File: rtl/eth_rx_pingpong_chk.sv
module eth_rx_pingpong_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_last,
  input logic             rx_irq,
  input logic [CNT_W-1:0] drop_count,
  input logic [1:0]       done_bits,
  input logic             frm_busy,
  input logic             wr_sel
);
  assert_irq_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_valid && rx_last));

  assert_done0_on_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_bits[0]) |-> $past(rx_valid && rx_last && (wr_sel == 1'b0)));

  assert_done1_on_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_bits[1]) |-> $past(rx_valid && rx_last && (wr_sel == 1'b1)));

  assert_drop_step_R6: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !frm_busy && (done_bits == 2'b11)) |=> (drop_count == $past(drop_count) + 1'b1));

  assert_sel_moves_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_sel != $past(wr_sel)) |-> $past(rx_valid && rx_last));
endmodule

bind eth_rx_pingpong eth_rx_pingpong_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last),
  .rx_irq(rx_irq), .drop_count(drop_count), .done_bits(done_bits),
  .frm_busy(frm_busy), .wr_sel(wr_sel)
);

// File: tb/test_eth_rx_pingpong.sv
module test_eth_rx_pingpong;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_data = 8'h0;
  logic        rx_valid = 1'b0;
  logic        rx_last = 1'b0;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_irq;
  logic [15:0] drop_count;

  int checks = 0;
  int errors = 0;

  logic [10:0] q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  eth_rx_pingpong i_eth_rx_pingpong (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_irq(rx_irq), .drop_count(drop_count)
  );

  function automatic logic [7:0] byte_at(input int seed, input int k);
    return 8'(seed * 31 + k * 7 + 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_word(input logic [10:0] a, input logic [31:0] d, input string tag);
    q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  // Scoreboard monitor: pops every expected item and compares with a bus read.
  task automatic drain();
    logic [31:0] d;
    while (q_addr.size() > 0) begin
      logic [10:0] a;
      logic [31:0] e;
      string t;
      a = q_addr.pop_front(); e = q_data.pop_front(); t = q_tag.pop_front();
      bus_read(a, d);
      chk(t, d, e);
    end
  endtask

  // Driver: sends a frame and, if it should be stored, pushes the expected words.
  task automatic send_frame(input int n, input int seed, input logic [10:0] base,
                            input bit stored, input logic exp_irq, input string tag);
    int nw;
    if (stored) begin
      nw = (n + 3) / 4;
      if (nw > 511) nw = 511;
      for (int w = 0; w < nw; w++) begin
        logic [31:0] word;
        word = '0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < n) word[31 - 8 * b -: 8] = byte_at(seed, 4 * w + b);
        expect_word(base + 11'(w), word, tag);
      end
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_data = byte_at(seed, k); rx_valid = 1'b1; rx_last = (k == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    chk({tag, " R7 irq after last"}, {31'h0, rx_irq}, {31'h0, exp_irq});
    @(negedge clk);
    chk("R7 irq one cycle", {31'h0, rx_irq}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 drop_count", {16'h0, drop_count}, 32'h0);
    chk("R1 irq", {31'h0, rx_irq}, 32'h0);
    bus_read(11'h5FF, d); chk("R1 status0", d, 32'h0);
    bus_read(11'h7FF, d); chk("R1 status1", d, 32'h0);

    // R5 interrupt enable write on area 0
    bus_write(11'h5FF, 32'h8);
    bus_read(11'h5FF, d); chk("R5 ie0 set", d, 32'h8);

    // R2 R3 R4: frame A to area 0 with partial word, irq on
    send_frame(7, 1, 11'h400, 1'b1, 1'b1, "R3 frameA");
    bus_read(11'h5FF, d); chk("R4 status0 done", d, 32'h9);
    drain();

    // R2: frame B to area 1, irq off
    send_frame(5, 2, 11'h600, 1'b1, 1'b0, "R2 frameB");
    bus_read(11'h7FF, d); chk("R4 status1 done", d, 32'h1);
    drain();

    // R6: both areas unread, frame C is discarded
    send_frame(9, 3, 11'h400, 1'b0, 1'b0, "R6 frameC");
    chk("R6 drop_count", {16'h0, drop_count}, 32'h1);
    send_frame(0, 0, 11'h400, 1'b0, 1'b0, "R6 none"); // no bytes, keeps pacing
    expect_word(11'h400, {byte_at(1,0), byte_at(1,1), byte_at(1,2), byte_at(1,3)}, "R6 area0 unchanged");
    expect_word(11'h401, {byte_at(1,4), byte_at(1,5), byte_at(1,6), 8'h00}, "R6 area0 unchanged w1");
    drain();
    bus_read(11'h5FF, d); chk("R6 status0 unchanged", d, 32'h9);
    bus_read(11'h7FF, d); chk("R6 status1 unchanged", d, 32'h1);

    // R9: data writes ignored
    bus_write(11'h400, 32'hDEADBEEF);
    expect_word(11'h400, {byte_at(1,0), byte_at(1,1), byte_at(1,2), byte_at(1,3)}, "R9 data write ignored");
    drain();

    // R5: writing 1 to done keeps it, writing 0 clears it
    bus_write(11'h5FF, 32'h9);
    bus_read(11'h5FF, d); chk("R5 done kept", d, 32'h9);
    bus_write(11'h5FF, 32'h8);
    bus_read(11'h5FF, d); chk("R5 done cleared", d, 32'h8);

    // R2: target stayed at area 0 after the discard
    send_frame(4, 4, 11'h400, 1'b1, 1'b1, "R2 frameD area0");
    drain();
    chk("R6 drop_count stays", {16'h0, drop_count}, 32'h1);

    // R8: overlong frame into area 1
    bus_write(11'h7FF, 32'h0);
    bus_read(11'h7FF, d); chk("R5 done1 cleared", d, 32'h0);
    send_frame(2050, 5, 11'h600, 1'b1, 1'b0, "R8 long frame");
    drain();
    bus_read(11'h7FF, d); chk("R8 status1 intact", d, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule